// File: doc/BRIEF.md
# Byte-Oriented Register ALU

This block is the execute stage for the register-to-register instruction group of a 16-bit processor. It is purely combinational: given the current values of the destination register (`rx_val`), the source register (`ry_val`), the 4-bit function code and the two register index fields of the instruction, it produces the value to be written back into the destination register and a write strobe for the register file.

The function codes cover several groups:
- Full-width step operations on the source, which subtract or add one or two.
- A plain copy.
- Byte-wide AND, OR and XOR.
- Wide add and subtract of the zero-extended low byte of the source.
- Two "high-byte" adds that fold a carry-derived byte into the upper half.
- Two transfers that move one byte between the halves.

Codes 14 and 15 belong to the I/O group, which is handled elsewhere. For those codes the block keeps the write strobe low.

Top module: `byte_reg_alu`

## Requirements
- R1: Codes 0, 1, 2 and 3 give `ry_val`-2, `ry_val`-1, `ry_val`+1 and `ry_val`+2, modulo 2^16.
- R2: Code 4 gives `ry_val`. When code 4 has `x_idx`=0 and `y_idx`=0, it is a no-operation: `wr_en` is 0 and `result` equals `rx_val`.
- R3: Codes 5, 6 and 7 place the AND, OR and XOR of the two low bytes in result[7:0], and result[15:8] is 8'h00.
- R4: Code 8 gives `rx_val` + {8'h00, `ry_val`[7:0]} and code 9 gives `rx_val` - {8'h00, `ry_val`[7:0]}, both modulo 2^16.
- R5: Code 10 sets result[7:0] to (`rx_val`[15:8] + `ry_val`[7:0]) mod 256. It sets result[15:8] to 8'h01 when that sum exceeds 255, and to 8'h00 otherwise.
- R6: Code 11 sets result[7:0] as in R5. It sets result[15:8] to 8'h00 when the sum exceeds 255, and to 8'hFF otherwise.
- R7: Code 12 gives {`rx_val`[15:8], `ry_val`[15:8]}, so the high half of the destination is kept.
- R8: Code 13 gives {`ry_val`[7:0], `rx_val`[7:0]}, so the low half of the destination is kept.
- R9: Codes 14 and 15 give `wr_en`=0 and `result`=`rx_val`.
- R10: For codes 0 to 13, `wr_en` is 1, except for the no-operation case in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rx_val | input | 16 | Current value of the destination register |
| ry_val | input | 16 | Current value of the source register |
| func | input | 4 | Function code of the instruction |
| x_idx | input | 4 | Destination register index field |
| y_idx | input | 4 | Source register index field |
| result | output | 16 | Value to write back to the destination |
| wr_en | output | 1 | Register write strobe |

## Verification
The bench aims at the carry edge of the high-byte adds.

Sums of exactly 255 and exactly 256 are the critical cases. A design that takes the carry from the wrong bit, or inverts it for code 11, puts 00 where 01 or FF belongs.

Wrap-around of the step operations at 0000 and FFFF is also exercised. A missing modulo there, or a step applied to `rx_val` instead of `ry_val`, gives a wrong 16-bit value.

Random operands with set high bytes show two further faults:
- Sign extension of the low byte in codes 8 and 9.
- A high byte left over by the byte logic operations.

The no-operation and I/O codes are checked on `wr_en`, since a stray write there would corrupt a register.

// File: rtl/bra_pkg.sv
package bra_pkg;
    localparam int DATA_W = 16;
    localparam int BYTE_W = DATA_W / 2;

    typedef enum logic [3:0] {
        FN_SUB2  = 4'd0,
        FN_SUB1  = 4'd1,
        FN_ADD1  = 4'd2,
        FN_ADD2  = 4'd3,
        FN_COPY  = 4'd4,
        FN_AND   = 4'd5,
        FN_OR    = 4'd6,
        FN_XOR   = 4'd7,
        FN_ADDLO = 4'd8,
        FN_SUBLO = 4'd9,
        FN_HADDC = 4'd10,
        FN_HADDB = 4'd11,
        FN_HI2LO = 4'd12,
        FN_LO2HI = 4'd13,
        FN_IO0   = 4'd14,
        FN_IO1   = 4'd15
    } alu_fn_e;
endpackage

// File: rtl/bra_step_unit.sv
// Full-width +/-1, +/-2 of the source operand, plus plain copy.
module bra_step_unit #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] src,
    input  logic [2:0]    sel,
    output logic [DW-1:0] out
);
    localparam logic [DW-1:0] ONE = DW'(1);
    localparam logic [DW-1:0] TWO = DW'(2);

    always_comb begin
        unique case (sel)
            3'd0:    out = src - TWO;
            3'd1:    out = src - ONE;
            3'd2:    out = src + ONE;
            3'd3:    out = src + TWO;
            default: out = src;
        endcase
    end
endmodule

// File: rtl/bra_logic_unit.sv
// Byte-wide bitwise operations; upper half of the result is cleared.
module bra_logic_unit #(
    parameter int DW = 16
) (
    input  logic [DW/2-1:0] a_lo,
    input  logic [DW/2-1:0] b_lo,
    input  logic [1:0]      sel,
    output logic [DW-1:0]   out
);
    localparam int BW = DW / 2;
    logic [BW-1:0] byte_res;

    always_comb begin
        unique case (sel)
            2'd0:    byte_res = a_lo & b_lo;
            2'd1:    byte_res = a_lo | b_lo;
            default: byte_res = a_lo ^ b_lo;
        endcase
        out = {{BW{1'b0}}, byte_res};
    end
endmodule

// File: rtl/bra_arith_unit.sv
// Wide add/sub of a zero-extended byte, and the two high-byte adds.
module bra_arith_unit #(
    parameter int DW = 16
) (
    input  logic [DW-1:0]   a,
    input  logic [DW/2-1:0] b_lo,
    input  logic [1:0]      sel,
    output logic [DW-1:0]   out
);
    localparam int BW = DW / 2;

    logic [DW-1:0] b_ext;
    logic [BW:0]   hsum;
    logic          carry;
    logic [BW-1:0] carry_byte;
    logic [BW-1:0] borrow_byte;

    always_comb begin
        b_ext       = {{BW{1'b0}}, b_lo};
        hsum        = {1'b0, a[DW-1:BW]} + {1'b0, b_lo};
        carry       = hsum[BW];
        carry_byte  = {{(BW-1){1'b0}}, carry};
        borrow_byte = carry ? {BW{1'b0}} : {BW{1'b1}};
        unique case (sel)
            2'd0:    out = a + b_ext;
            2'd1:    out = a - b_ext;
            2'd2:    out = {carry_byte, hsum[BW-1:0]};
            default: out = {borrow_byte, hsum[BW-1:0]};
        endcase
    end
endmodule

// File: rtl/bra_half_unit.sv
// Byte transfers between halves; the untouched half of the destination is kept.
module bra_half_unit #(
    parameter int DW = 16
) (
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    input  logic          hi_to_lo,
    output logic [DW-1:0] out
);
    localparam int BW = DW / 2;

    always_comb begin
        if (hi_to_lo) out = {a[DW-1:BW], b[DW-1:BW]};
        else          out = {b[BW-1:0], a[BW-1:0]};
    end
endmodule

// File: rtl/byte_reg_alu.sv
module byte_reg_alu
    import bra_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int IW = 4
) (
    input  logic [DW-1:0] rx_val,
    input  logic [DW-1:0] ry_val,
    input  logic [3:0]    func,
    input  logic [IW-1:0] x_idx,
    input  logic [IW-1:0] y_idx,
    output logic [DW-1:0] result,
    output logic          wr_en
);
    localparam int BW = DW / 2;

    alu_fn_e       fn;
    logic [DW-1:0] step_out, logic_out, arith_out, half_out;
    logic          is_nop;

    assign fn = alu_fn_e'(func);

    bra_step_unit #(.DW(DW)) u_step (
        .src (ry_val),
        .sel (func[2:0]),
        .out (step_out)
    );

    bra_logic_unit #(.DW(DW)) u_logic (
        .a_lo (rx_val[BW-1:0]),
        .b_lo (ry_val[BW-1:0]),
        .sel  (func[1:0] - 2'd1),
        .out  (logic_out)
    );

    bra_arith_unit #(.DW(DW)) u_arith (
        .a    (rx_val),
        .b_lo (ry_val[BW-1:0]),
        .sel  (func[1:0]),
        .out  (arith_out)
    );

    bra_half_unit #(.DW(DW)) u_half (
        .a        (rx_val),
        .b        (ry_val),
        .hi_to_lo (~func[0]),
        .out      (half_out)
    );

    always_comb begin
        is_nop = (fn == FN_COPY) && (x_idx == '0) && (y_idx == '0);
        wr_en  = 1'b1;
        unique case (fn)
            FN_SUB2, FN_SUB1, FN_ADD1, FN_ADD2:   result = step_out;
            FN_COPY: begin
                result = is_nop ? rx_val : step_out;
                wr_en  = ~is_nop;
            end
            FN_AND, FN_OR, FN_XOR:                 result = logic_out;
            FN_ADDLO, FN_SUBLO, FN_HADDC, FN_HADDB: result = arith_out;
            FN_HI2LO, FN_LO2HI:                    result = half_out;
            default: begin
                result = rx_val;
                wr_en  = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/byte_reg_alu_chk.sv
module byte_reg_alu_chk #(
    parameter int DW = 16,
    parameter int IW = 4
) (
    input logic [DW-1:0] rx_val,
    input logic [DW-1:0] ry_val,
    input logic [3:0]    func,
    input logic [IW-1:0] x_idx,
    input logic [IW-1:0] y_idx,
    input logic [DW-1:0] result,
    input logic          wr_en
);
    localparam int BW = DW / 2;

    always_comb begin
        if (func >= 4'd14) begin
            AST_IO_NO_WRITE: assert (!wr_en && result == rx_val) else $error("io write"); // R9
        end
        if (func == 4'd4 && x_idx == '0 && y_idx == '0) begin
            AST_NOP_NO_WRITE: assert (!wr_en) else $error("nop write"); // R2
        end
        if (func <= 4'd13 && !(func == 4'd4 && x_idx == '0 && y_idx == '0)) begin
            AST_OP_WRITES: assert (wr_en) else $error("missing write"); // R10
        end
        if (func >= 4'd5 && func <= 4'd7) begin
            AST_LOGIC_HIGH_ZERO: assert (result[DW-1:BW] == '0) else $error("logic high"); // R3
        end
        if (func == 4'd10) begin
            AST_HADDC_HIGH_RANGE: assert (result[DW-1:1] == '0 || result[DW-1:BW] <= 8'd1) else $error("haddc high"); // R5
        end
        if (func == 4'd11) begin
            AST_HADDB_HIGH_RANGE: assert (result[DW-1:BW] == '0 || (&result[DW-1:BW])) else $error("haddb high"); // R6
        end
        if (func == 4'd12) begin
            AST_HI2LO_KEEP: assert (result[DW-1:BW] == rx_val[DW-1:BW]) else $error("hi2lo keep"); // R7
        end
        if (func == 4'd13) begin
            AST_LO2HI_KEEP: assert (result[BW-1:0] == rx_val[BW-1:0] && result[DW-1:BW] == ry_val[BW-1:0]) else $error("lo2hi keep"); // R8
        end
    end
endmodule

bind byte_reg_alu byte_reg_alu_chk #(.DW(DW), .IW(IW)) u_chk (
    .rx_val (rx_val),
    .ry_val (ry_val),
    .func   (func),
    .x_idx  (x_idx),
    .y_idx  (y_idx),
    .result (result),
    .wr_en  (wr_en)
);

// File: tb/byte_reg_alu_tb.sv
module byte_reg_alu_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] rx_val, ry_val, result;
    logic [3:0]  func, x_idx, y_idx;
    logic        wr_en;
    int          checks = 0;
    int          errors = 0;

    always #5 clk = ~clk;

    byte_reg_alu u_dut (
        .rx_val (rx_val),
        .ry_val (ry_val),
        .func   (func),
        .x_idx  (x_idx),
        .y_idx  (y_idx),
        .result (result),
        .wr_en  (wr_en)
    );

    function automatic string tag_of(input int f, input int xi, input int yi);
        if (f <= 3) return "R1";
        if (f == 4) return (xi == 0 && yi == 0) ? "R2" : "R10";
        if (f <= 7) return "R3";
        if (f <= 9) return "R4";
        if (f == 10) return "R5";
        if (f == 11) return "R6";
        if (f == 12) return "R7";
        if (f == 13) return "R8";
        return "R9";
    endfunction

    task automatic model(input int f, input int a, input int b, input int xi, input int yi,
                         output int r, output int w);
        int hs, ylo, alo, ahi;
        ylo = b % 256; alo = a % 256; ahi = a / 256;
        hs  = ahi + ylo;
        w = 1;
        case (f)
            0: r = (b + 65536 - 2) % 65536;
            1: r = (b + 65536 - 1) % 65536;
            2: r = (b + 1) % 65536;
            3: r = (b + 2) % 65536;
            4: begin
                if (xi == 0 && yi == 0) begin r = a; w = 0; end
                else r = b;
            end
            5: r = alo & ylo;
            6: r = alo | ylo;
            7: r = alo ^ ylo;
            8: r = (a + ylo) % 65536;
            9: r = (a + 65536 - ylo) % 65536;
            10: r = ((hs > 255) ? 256 : 0) + hs % 256;
            11: r = ((hs > 255) ? 0 : 255 * 256) + hs % 256;
            12: r = ahi * 256 + b / 256;
            13: r = ylo * 256 + alo;
            default: begin r = a; w = 0; end
        endcase
    endtask

    task automatic apply(input int f, input int a, input int b, input int xi, input int yi);
        int er, ew;
        @(posedge clk);
        func = 4'(f); rx_val = 16'(a); ry_val = 16'(b); x_idx = 4'(xi); y_idx = 4'(yi);
        @(negedge clk);
        model(f, a, b, xi, yi, er, ew);
        checks++;
        if (int'(result) != er || int'(wr_en) != ew) begin
            errors++;
            $display("FAIL %s func=%0d rx=%h ry=%h: result=%h wr_en=%0d expected result=%h wr_en=%0d",
                     tag_of(f, xi, yi), f, a, b, result, wr_en, er[15:0], ew);
        end
    endtask

    initial begin
        #200000000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        func = 4'd4; rx_val = '0; ry_val = '0; x_idx = 4'd1; y_idx = 4'd2;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // R1 step wrap-around at both ends
        apply(0, 16'h1234, 16'h0000, 1, 2);
        apply(1, 16'h1234, 16'h0000, 1, 2);
        apply(2, 16'h1234, 16'hFFFF, 1, 2);
        apply(3, 16'h1234, 16'hFFFE, 1, 2);
        // R2 copy and no-operation; R10 copy with nonzero fields
        apply(4, 16'hABCD, 16'h5A5A, 0, 0);
        apply(4, 16'hABCD, 16'h5A5A, 0, 3);
        // R3 high byte cleared even with set high inputs
        apply(5, 16'hFFF0, 16'hFF3C, 1, 2);
        apply(6, 16'hFF00, 16'hFF81, 1, 2);
        apply(7, 16'hAAAA, 16'h55FF, 1, 2);
        // R4 zero extension and wrap
        apply(8, 16'hFFFF, 16'hFF01, 1, 2);
        apply(9, 16'h0000, 16'h00FF, 1, 2);
        // R5 R6 carry boundary: sums 255, 256, 510
        for (int f = 10; f <= 11; f++) begin
            apply(f, 16'h7F11, 16'h0080, 1, 2);
            apply(f, 16'h8022, 16'h0080, 1, 2);
            apply(f, 16'hFF33, 16'h00FF, 1, 2);
            apply(f, 16'h0044, 16'h0000, 1, 2);
        end
        // R7 R8 half transfers
        apply(12, 16'h1234, 16'hABCD, 1, 2);
        apply(13, 16'h1234, 16'hABCD, 1, 2);
        // R9 I/O codes
        apply(14, 16'hBEEF, 16'h1111, 1, 2);
        apply(15, 16'hBEEF, 16'h1111, 0, 0);
        // random sweep of every code
        for (int n = 0; n < 2000; n++) begin
            apply(n % 16, int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                  int'($urandom_range(0, 15)), int'($urandom_range(0, 15)));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule